// File: doc/BRIEF.md
# Clock Buffer Power Sequencer with Latched Lock

This block steps a differential clock buffer from supply-good through a fixed settling delay, then waits for a usable input clock, a released power-down request and a locked PLL before it lets the outputs run. It raises a lock flag at the moment the outputs start. The flag then stays high, whatever the PLL reports, until a power-down request is accepted or the supply drops. The PLL and the input-clock detector are outside the block; it only sees their digital status bits.

A power-down request (active low) is only honoured once it has been seen low at two consecutive rising edges of the output complement clock. The outputs then stop at the next falling edge of that clock. While stopped, a mode bit chooses whether the true leg is held driven high or both legs float. The complement clock is brought in as a level and sampled by the free-running timer clock. Its edges are found in that domain, so the timer clock must run at more than twice the complement-clock rate. All other inputs are expected to be synchronous to the timer clock already.

Top module: `clkbuf_pwrseq`

## Requirements
- R1: After a synchronous reset, `run_o`, `lock_o` and `true_hi_o` are all 0.
- R2: When `pwr_good` is first sampled high at a timer-clock edge (counted as edge 1) and every other start condition already holds, `run_o` rises after edge DELAY_CYCLES+2. In between, the sequencer spends exactly DELAY_CYCLES cycles in its settling delay.
- R3: From the waiting state, `run_o` rises only after an edge at which `clk_valid`, `pdn_n` and `pll_locked` are all 1. While any of them is 0, `run_o` stays 0.
- R4: `lock_o` rises after the same edge at which `run_o` rises.
- R5: While running, a low `pll_locked` or `clk_valid` changes neither `lock_o` nor `run_o`. `lock_o` falls only on reset, supply loss or an accepted power-down.
- R6: The complement clock has a rising edge at a timer edge where `difc_lvl` is 1 and was 0 at the previous timer edge. A power-down is accepted at the second consecutive such rising edge with `pdn_n` at 0. A rising edge with `pdn_n` at 1 restarts the count. `lock_o` falls after the accepting edge, while `run_o` stays 1.
- R7: After acceptance, `run_o` falls after the first complement-clock falling edge, that is, the first timer edge where `difc_lvl` is 0 and was 1 before.
- R8: While stopped by a power-down, `true_hi_o` is 1 when `pdn_float` is 0 and is 0 when `pdn_float` is 1. The bit acts at once. `true_hi_o` is 0 whenever `run_o` is 1.
- R9: `pwr_good` sampled at 0 in any state clears `run_o`, `lock_o` and `true_hi_o` after that edge. When `pwr_good` returns, the full delay of R2 starts over.
- R10: After a power-down stop, the block returns to running (with `lock_o` 1 and `true_hi_o` 0) after the first edge at which the R3 conditions all hold, without a new settling delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timer clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply is valid |
| pdn_n | input | 1 | Power-down request, active low |
| clk_valid | input | 1 | Input reference clock detected |
| pll_locked | input | 1 | PLL lock status |
| difc_lvl | input | 1 | Output complement clock, sampled as a level |
| pdn_float | input | 1 | Stop mode: 0 holds true leg high, 1 floats both legs |
| run_o | output | 1 | Differential outputs enabled and toggling |
| true_hi_o | output | 1 | True leg held driven high while stopped |
| lock_o | output | 1 | Latched lock indicator |

## Verification
The hardest situation to reach is an accepted power-down that sits pending between its second qualifying rising edge and the following falling edge. It needs a particular ordering of `pdn_n` against the complement-clock edges. So does the count reset, where a single high sample between two low ones must cancel the qualification. The bench switches the complement-clock generator off for these cases and sets `difc_lvl` level by level, so each edge lands on a known timer cycle. Long random stretches then vary the complement-clock half-period, the request pattern and short supply drops. A cycle model built from the requirements checks every output on every cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DELAY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t edge_of(input logic cur, input logic prev);
        edge_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay import pwrseq_pkg::*; #(
    parameter int DELAY_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic done_o
);
    localparam int unsigned CW = width_for(DELAY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = count_en && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_pdn_qual.sv
module pwrseq_pdn_qual import pwrseq_pkg::*; #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic difc_i,
    input  logic pdn_n_i,
    output logic accept_o,
    output logic park_o
);
    localparam int unsigned QW = width_for(QUAL_EDGES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUAL_EDGES - 1);

    logic          difc_q;
    logic [QW-1:0] low_cnt_q;
    logic          pending_q;
    edge_t         edg;

    assign edg = edge_of(difc_i, difc_q);

    always_ff @(posedge clk) begin
        if (rst) difc_q <= 1'b0;
        else     difc_q <= difc_i;
    end

    assign accept_o = arm_i && edg.rise && !pdn_n_i && !pending_q && (low_cnt_q == Q_LAST);
    assign park_o   = arm_i && edg.fall && pending_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            low_cnt_q <= '0;
            pending_q <= 1'b0;
        end else begin
            if (edg.rise) begin
                if (pdn_n_i)                low_cnt_q <= '0;
                else if (low_cnt_q < Q_LAST) low_cnt_q <= low_cnt_q + 1'b1;
            end
            if (accept_o) pending_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwrseq_lock_latch.sv
module pwrseq_lock_latch (
    input  logic clk,
    input  logic clr_i,
    input  logic set_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (clr_i)      q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end
endmodule

// File: rtl/clkbuf_pwrseq.sv
module clkbuf_pwrseq import pwrseq_pkg::*; #(
    parameter int DELAY_CYCLES = 6250,
    parameter int QUAL_EDGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic pdn_n,
    input  logic clk_valid,
    input  logic pll_locked,
    input  logic difc_lvl,
    input  logic pdn_float,
    output logic run_o,
    output logic true_hi_o,
    output logic lock_o
);
    seq_state_e state_q;
    logic       parked_q;
    logic       power_lost;
    logic       ready;
    logic       delay_done;
    logic       accept;
    logic       park;
    logic       arm;
    logic       start_run;

    assign power_lost = rst || !pwr_good;
    assign ready      = clk_valid && pdn_n && pll_locked;
    assign arm        = (state_q == ST_RUN);
    assign start_run  = (state_q == ST_WAIT) && ready;

    pwrseq_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .count_en (state_q == ST_DELAY),
        .done_o   (delay_done)
    );

    pwrseq_pdn_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm),
        .difc_i   (difc_lvl),
        .pdn_n_i  (pdn_n),
        .accept_o (accept),
        .park_o   (park)
    );

    pwrseq_lock_latch u_lock (
        .clk   (clk),
        .clr_i (power_lost || accept),
        .set_i (start_run),
        .q_o   (lock_o)
    );

    always_ff @(posedge clk) begin
        if (power_lost) begin
            state_q  <= ST_OFF;
            parked_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF:   state_q <= ST_DELAY;
                ST_DELAY: if (delay_done) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (ready) begin
                        state_q  <= ST_RUN;
                        parked_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (park) begin
                        state_q  <= ST_WAIT;
                        parked_q <= 1'b1;
                    end
                end
                default:  state_q <= ST_OFF;
            endcase
        end
    end

    assign run_o     = (state_q == ST_RUN);
    assign true_hi_o = parked_q && !pdn_float;
endmodule

// File: rtl/clkbuf_pwrseq_chk.sv
module clkbuf_pwrseq_chk #(
    parameter int DELAY_CYCLES = 6250
) (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic pdn_n,
    input logic clk_valid,
    input logic pll_locked,
    input logic difc_lvl,
    input logic pdn_float,
    input logic run_o,
    input logic true_hi_o,
    input logic lock_o
);
    localparam int AW = $clog2(DELAY_CYCLES + 3) + 1;
    localparam logic [AW-1:0] AGE_MAX = AW'(DELAY_CYCLES + 2);

    logic [AW-1:0] pg_age;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good)     pg_age <= '0;
        else if (pg_age < AGE_MAX) pg_age <= pg_age + 1'b1;
    end

    // R2
    delay_elapsed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> (pg_age > AW'(DELAY_CYCLES)));

    // R3
    start_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> $past(clk_valid && pdn_n && pll_locked && pwr_good));

    // R4
    lock_with_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_o) |-> lock_o);

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(rst || !pwr_good || !pdn_n));

    // R6
    lock_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(rst || !pwr_good || difc_lvl));

    // R7
    park_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_o) |-> $past(rst || !pwr_good || !difc_lvl));

    // R8
    park_mode_chk: assert property (@(posedge clk) disable iff (rst)
        true_hi_o |-> (!run_o && !pdn_float));

    // R9
    power_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!run_o && !lock_o && !true_hi_o));
endmodule

bind clkbuf_pwrseq clkbuf_pwrseq_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_good   (pwr_good),
    .pdn_n      (pdn_n),
    .clk_valid  (clk_valid),
    .pll_locked (pll_locked),
    .difc_lvl   (difc_lvl),
    .pdn_float  (pdn_float),
    .run_o      (run_o),
    .true_hi_o  (true_hi_o),
    .lock_o     (lock_o)
);

// File: tb/clkbuf_pwrseq_tb.sv
`timescale 1ns/1ps
module clkbuf_pwrseq_tb;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst, pwr_good, pdn_n, clk_valid, pll_locked, difc, pdn_float;
    logic run_o, true_hi_o, lock_o;

    always #2.5 clk = ~clk;

    clkbuf_pwrseq #(.DELAY_CYCLES(D), .QUAL_EDGES(2)) u_dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .pdn_n(pdn_n),
        .clk_valid(clk_valid), .pll_locked(pll_locked), .difc_lvl(difc),
        .pdn_float(pdn_float), .run_o(run_o), .true_hi_o(true_hi_o), .lock_o(lock_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // requirement-level model state
    int m_st = 0;     // 0 off, 1 delay, 2 wait, 3 run
    int m_cnt = 0;
    int m_low = 0;
    bit m_pend = 0, m_lock = 0, m_park = 0, m_dq = 0;

    bit difc_auto = 0;
    int hcnt = 2;

    function automatic bit exp_run();  return m_st == 3;            endfunction
    function automatic bit exp_thi();  return m_park && !pdn_float; endfunction

    task automatic model_step();
        bit rise, fall, acc, prk, rdy;
        int n_st;
        rise = difc && !m_dq;
        fall = !difc && m_dq;
        rdy  = clk_valid && pdn_n && pll_locked;
        acc  = (m_st == 3) && rise && !pdn_n && (m_low == 1) && !m_pend;
        prk  = (m_st == 3) && fall && m_pend;
        n_st = m_st;
        if (rst || m_st != 1) m_cnt = 0;
        else if (m_cnt != D - 1) m_cnt++;
        if (rst || m_st != 3) begin
            m_low = 0; m_pend = 0;
        end else begin
            if (rise) begin
                if (pdn_n) m_low = 0;
                else if (m_low < 1) m_low++;
            end
            if (acc) m_pend = 1;
        end
        if (rst || !pwr_good || acc) m_lock = 0;
        else if (m_st == 2 && rdy) m_lock = 1;
        if (rst || !pwr_good) begin
            n_st = 0; m_park = 0;
        end else begin
            case (m_st)
                0: n_st = 1;
                1: if (m_cnt_was_last()) n_st = 2;
                2: if (rdy) begin n_st = 3; m_park = 0; end
                default: if (prk) begin n_st = 2; m_park = 1; end
            endcase
        end
        m_st = n_st;
        m_dq = rst ? 1'b0 : difc;
    endtask

    // delay terminal flag uses the count before this edge's update
    int m_cnt_prev = 0;
    function automatic bit m_cnt_was_last(); return m_cnt_prev == D - 1; endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        m_cnt_prev = m_cnt;
        model_step();
        @(negedge clk);
        n_chk++;
        if (run_o !== exp_run() || lock_o !== m_lock || true_hi_o !== exp_thi()) begin
            n_err++;
            $display("FAIL %s: actual run/lock/thi %b%b%b expected %b%b%b at %0t",
                     cur_req, run_o, lock_o, true_hi_o, exp_run(), m_lock, exp_thi(), $time);
        end
        if (difc_auto) begin
            if (hcnt <= 1) begin
                difc = ~difc;
                hcnt = 2 + int'($urandom_range(2));
            end else begin
                hcnt--;
            end
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_difc(bit v);
        difc = v;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        rst = 1; pwr_good = 0; pdn_n = 1; clk_valid = 1; pll_locked = 1;
        difc = 0; pdn_float = 0;
        @(negedge clk);
        cur_req = "R1";
        ticks(3);
        chk("R1", run_o, 1'b0);
        chk("R1", lock_o, 1'b0);
        chk("R1", true_hi_o, 1'b0);
        rst = 0;
        tick();

        // R2: settling delay length
        cur_req = "R2";
        pwr_good = 1;
        n = 0;
        do begin tick(); n++; end while (!run_o && n < 60);
        chk("R2 start edge", (n == D + 2), 1'b1);
        chk("R4", lock_o, 1'b1);

        // R5: lock sticky against PLL and clock status
        cur_req = "R5";
        pll_locked = 0; clk_valid = 0;
        ticks(10);
        chk("R5", lock_o, 1'b1);
        chk("R5", run_o, 1'b1);
        pll_locked = 1; clk_valid = 1;
        tick();

        // R6/R7: two qualifying rising edges, then park at falling edge
        cur_req = "R6";
        pulse_difc(0);
        pdn_n = 0;
        tick();
        pulse_difc(1);
        chk("R6 first edge", lock_o, 1'b1);
        pulse_difc(0);
        pulse_difc(1);
        chk("R6 accept", lock_o, 1'b0);
        chk("R6 still running", run_o, 1'b1);
        cur_req = "R7";
        ticks(2);
        chk("R7 waits for fall", run_o, 1'b1);
        pulse_difc(0);
        chk("R7 park", run_o, 1'b0);
        chk("R8 driven mode", true_hi_o, 1'b1);

        // R10: return without settling delay
        cur_req = "R10";
        ticks(3);
        chk("R10 held", run_o, 1'b0);
        pdn_n = 1;
        tick();
        chk("R10 rerun", run_o, 1'b1);
        chk("R10 lock", lock_o, 1'b1);
        chk("R10 leg", true_hi_o, 1'b0);

        // R6: a high sample restarts the count
        cur_req = "R6";
        pdn_n = 0;
        pulse_difc(1);
        pulse_difc(0);
        pdn_n = 1;
        pulse_difc(1);
        pulse_difc(0);
        pdn_n = 0;
        pulse_difc(1);
        chk("R6 count restart", lock_o, 1'b1);
        pdn_float = 1;
        pulse_difc(0);
        pulse_difc(1);
        chk("R6 second accept", lock_o, 1'b0);
        cur_req = "R8";
        pulse_difc(0);
        chk("R7 park again", run_o, 1'b0);
        chk("R8 float mode", true_hi_o, 1'b0);
        pdn_float = 0;
        tick();
        chk("R8 live mode", true_hi_o, 1'b1);

        // R3: each start condition gates running
        cur_req = "R3";
        pdn_n = 1; pll_locked = 0;
        ticks(5);
        chk("R3 pll", run_o, 1'b0);
        pll_locked = 1; clk_valid = 0;
        ticks(5);
        chk("R3 clk", run_o, 1'b0);
        clk_valid = 1; pdn_n = 0;
        ticks(5);
        chk("R3 pdn", run_o, 1'b0);
        pdn_n = 1;
        tick();
        chk("R3 all", run_o, 1'b1);

        // R9: power loss while running and while settling
        cur_req = "R9";
        pwr_good = 0;
        tick();
        chk("R9 run", run_o, 1'b0);
        chk("R9 lock", lock_o, 1'b0);
        pwr_good = 1;
        ticks(4);
        pwr_good = 0;
        tick();
        pwr_good = 1;
        n = 0;
        do begin tick(); n++; end while (!run_o && n < 60);
        chk("R9 delay restarts", (n == D + 2), 1'b1);

        // random phase
        cur_req = "R6/R7/R9 random";
        difc_auto = 1;
        for (int i = 0; i < 4000; i++) begin
            if (pwr_good && $urandom_range(299) == 0) pwr_good = 0;
            else if (!pwr_good && $urandom_range(2) == 0) pwr_good = 1;
            if (pdn_n && $urandom_range(24) == 0) pdn_n = 0;
            else if (!pdn_n && $urandom_range(14) == 0) pdn_n = 1;
            if ($urandom_range(39) == 0) clk_valid = ~clk_valid;
            if ($urandom_range(39) == 0) pll_locked = ~pll_locked;
            if ($urandom_range(49) == 0) pdn_float = ~pdn_float;
            tick();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule